// File: doc/BRIEF.md
# Pulse-Pause Frame Encoder

The block turns a short command word into a pulse-pause waveform on one carrier-enable line. The waveform travels from a reader to a contactless card. Each bit opens with a fixed stretch of carrier-off, called the gap. A stretch of carrier-on, called the mark, follows the gap. The bit's value sets the total length of gap plus mark: a one lasts longer than a zero. Bits go out least significant first. After the last data bit, a closing gap ends the frame and the carrier returns on.

All durations are counted in ticks. A tick is a single-cycle enable, normally the system clock divided by 32, so the block needs no divider of its own. When the closing gap ends, the block pulses `done`. In the same cycle it pulses `timer_restart`, which restarts a shared timer so that the reply window is measured from the end of the frame. Between frames the carrier stays on.

Top module: `pp_frame_encoder`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `carrier_en` is 1, `busy` is 0, and `done` and `timer_restart` are 0.
- R2: A `start` pulse sampled while idle captures `frame_data` and `frame_len`. From the next cycle `busy` is 1 and `carrier_en` is 0.
- R3: Data bits are sent least significant bit first: bit 0 of `frame_data` is sent first.
- R4: Every data bit begins with a gap of exactly PAUSE_TICKS ticks with `carrier_en` at 0.
- R5: A 1 bit lasts ONE_TICKS ticks in total and a 0 bit lasts ZERO_TICKS ticks in total, gap included. For the rest of the bit `carrier_en` is 1.
- R6: After the last data bit, a closing gap of PAUSE_TICKS ticks with `carrier_en` at 0 ends the frame. After it `carrier_en` is 1 again.
- R7: In the cycle after the clock edge that samples the last tick of the closing gap, `done` and `timer_restart` are both 1 for exactly one cycle, and in that same cycle `busy` is 0. There is one such pulse per accepted frame.
- R8: A `start` sampled while `busy` is 1 is ignored. The frame in progress continues unchanged and no extra frame follows.
- R9: A `frame_len` of 0 produces only the closing gap.
- R10: A `frame_len` greater than MAX_BITS is treated as MAX_BITS, and only the low MAX_BITS data bits are sent.
- R11: Only `tick_en` pulses sampled while `busy` is 1 count toward durations. Ticks while idle have no effect, and the waveform in ticks does not depend on how the ticks are spaced in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Single-cycle time-base enable |
| start | input | 1 | Frame start strobe |
| frame_data | input | MAX_BITS | Bits to send, bit 0 first |
| frame_len | input | $clog2(MAX_BITS+1) | Number of data bits |
| carrier_en | output | 1 | 1 = carrier on, 0 = gap |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| timer_restart | output | 1 | One-cycle restart for the shared reply timer |

## Verification
The bench builds the encoder with MAX_BITS=16, PAUSE_TICKS=3, ZERO_TICKS=6 and ONE_TICKS=10. These short durations keep frames of the full sixteen bits to a few hundred cycles. A wide 5-bit length port is then available, so the clamping variant can be driven with lengths of 20 and 31. The bench drives ticks on every cycle, on every third cycle and from a shift-register pattern. This exposes any dependence on tick spacing, and it places starts that collide with a frame in progress.

// File: rtl/ppenc_pkg.sv
package ppenc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_GAP  = 2'd1,
      PH_MARK = 2'd2,
      PH_TAIL = 2'd3
   } phase_e;

   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/ppenc_tick_timer.sv
module ppenc_tick_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         left_q <= '0;
      else if (load)
         left_q <= load_val;
      else if (tick_en && left_q != '0)
         left_q <= left_q - 1'b1;
   end

   assign expire = tick_en && (left_q == CNT_W'(1));

endmodule

// File: rtl/ppenc_bit_seq.sv
module ppenc_bit_seq #(
   parameter int MAX_BITS = 16,
   parameter int LEN_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [MAX_BITS-1:0] data_in,
   input  logic [LEN_W-1:0]    len_in,
   input  logic                advance,
   output logic                cur_bit,
   output logic                last_bit,
   output logic                len_zero
);

   localparam int LEN_TOP = (1 << LEN_W) - 1;

   logic [LEN_W-1:0]    len_eff;
   logic [MAX_BITS-1:0] shift_q;
   logic [LEN_W-1:0]    left_q;

   generate
      if (LEN_TOP > MAX_BITS) begin : g_clamp
         assign len_eff = (len_in > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : len_in;
      end else begin : g_pass
         assign len_eff = len_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         left_q  <= '0;
      end else if (load) begin
         shift_q <= data_in;
         left_q  <= len_eff;
      end else if (advance) begin
         shift_q <= shift_q >> 1;
         left_q  <= left_q - 1'b1;
      end
   end

   assign cur_bit  = shift_q[0];
   assign last_bit = (left_q == LEN_W'(1));
   assign len_zero = (len_in == '0);

   // R10: the captured bit count never exceeds the frame limit
   assert_len_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (left_q <= LEN_W'(MAX_BITS)));

endmodule

// File: rtl/pp_frame_encoder.sv
module pp_frame_encoder
   import ppenc_pkg::*;
#(
   parameter int MAX_BITS    = 16,
   parameter int PAUSE_TICKS = 30,
   parameter int ZERO_TICKS  = 90,
   parameter int ONE_TICKS   = 150
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               tick_en,
   input  logic                               start,
   input  logic [MAX_BITS-1:0]                frame_data,
   input  logic [$clog2(MAX_BITS+1)-1:0]      frame_len,
   output logic                               carrier_en,
   output logic                               busy,
   output logic                               done,
   output logic                               timer_restart
);

   localparam int LEN_W     = $clog2(MAX_BITS + 1);
   localparam int CNT_W     = bits_for(ONE_TICKS);
   localparam int ONE_MARK  = ONE_TICKS - PAUSE_TICKS;
   localparam int ZERO_MARK = ZERO_TICKS - PAUSE_TICKS;

   generate
      if (MAX_BITS < 1) begin : g_bad_bits
         $error("MAX_BITS must be at least 1");
      end
      if (PAUSE_TICKS < 1) begin : g_bad_pause
         $error("PAUSE_TICKS must be at least 1");
      end
      if (ZERO_TICKS <= PAUSE_TICKS) begin : g_bad_zero
         $error("ZERO_TICKS must exceed PAUSE_TICKS");
      end
      if (ONE_TICKS <= ZERO_TICKS) begin : g_bad_one
         $error("ONE_TICKS must exceed ZERO_TICKS");
      end
   endgenerate

   phase_e           ph_q, ph_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             seq_load, seq_adv, fin;
   logic             expire, cur_bit, last_bit, len_zero;
   logic             done_q;

   ppenc_tick_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (expire)
   );

   ppenc_bit_seq #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (seq_load),
      .data_in  (frame_data),
      .len_in   (frame_len),
      .advance  (seq_adv),
      .cur_bit  (cur_bit),
      .last_bit (last_bit),
      .len_zero (len_zero)
   );

   always_comb begin
      ph_d     = ph_q;
      tmr_load = 1'b0;
      tmr_val  = CNT_W'(PAUSE_TICKS);
      seq_load = 1'b0;
      seq_adv  = 1'b0;
      fin      = 1'b0;
      unique case (ph_q)
         PH_IDLE: if (start) begin
            seq_load = 1'b1;
            tmr_load = 1'b1;
            ph_d     = len_zero ? PH_TAIL : PH_GAP;
         end
         PH_GAP: if (expire) begin
            tmr_load = 1'b1;
            tmr_val  = cur_bit ? CNT_W'(ONE_MARK) : CNT_W'(ZERO_MARK);
            ph_d     = PH_MARK;
         end
         PH_MARK: if (expire) begin
            seq_adv  = 1'b1;
            tmr_load = 1'b1;
            ph_d     = last_bit ? PH_TAIL : PH_GAP;
         end
         PH_TAIL: if (expire) begin
            fin  = 1'b1;
            ph_d = PH_IDLE;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         done_q <= fin;
      end
   end

   assign carrier_en    = (ph_q == PH_IDLE) || (ph_q == PH_MARK);
   assign busy          = (ph_q != PH_IDLE);
   assign done          = done_q;
   assign timer_restart = done_q;

   // Checking counter: ticks seen in the current phase, independent of the timer
   logic [CNT_W-1:0] chk_ticks;
   always_ff @(posedge clk) begin
      if (!rst_n)
         chk_ticks <= '0;
      else if (ph_d != ph_q)
         chk_ticks <= '0;
      else if (tick_en && ph_q != PH_IDLE)
         chk_ticks <= chk_ticks + 1'b1;
   end

   assert_gap_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_GAP && expire) |-> (chk_ticks == CNT_W'(PAUSE_TICKS - 1)));

   assert_mark_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_MARK && expire) |->
         (chk_ticks == (cur_bit ? CNT_W'(ONE_MARK - 1) : CNT_W'(ZERO_MARK - 1))));

   assert_tail_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_TAIL && expire) |-> (chk_ticks == CNT_W'(PAUSE_TICKS - 1)));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && carrier_en));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !expire) |=> (ph_q == $past(ph_q)));

   assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && frame_len == '0) |=> (ph_q == PH_TAIL));

endmodule

// File: tb/tb_pp_frame_encoder.sv
`timescale 1ns/1ps
module tb_pp_frame_encoder;

   localparam int MAXB  = 16;
   localparam int PAUSE = 3;
   localparam int ZERO  = 6;
   localparam int ONE   = 10;
   localparam int LW    = $clog2(MAXB + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tick_en = 1'b0;
   logic            start = 1'b0;
   logic [MAXB-1:0] frame_data = '0;
   logic [LW-1:0]   frame_len = '0;
   logic            carrier_en, busy, done, timer_restart;

   int    errors = 0;
   int    checks = 0;
   string cur_req = "R1";
   int    tick_mode = 0;
   int    div_cnt = 0;
   logic [15:0] lfsr = 16'hACE1;

   int q_lvl[$];
   int q_len[$];
   int m_rem = 0;
   bit m_done = 1'b0;
   int frames_started = 0;
   int dut_done_cnt = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   pp_frame_encoder #(
      .MAX_BITS(MAXB), .PAUSE_TICKS(PAUSE), .ZERO_TICKS(ZERO), .ONE_TICKS(ONE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
      .frame_data(frame_data), .frame_len(frame_len),
      .carrier_en(carrier_en), .busy(busy), .done(done), .timer_restart(timer_restart)
   );

   // Behavioural reference: a queue of (level, ticks) phases
   always @(posedge clk) begin
      if (!rst_n) begin
         q_lvl.delete();
         q_len.delete();
         m_done = 1'b0;
      end else begin
         m_done = 1'b0;
         if (q_len.size() != 0) begin
            if (tick_en) begin
               m_rem = m_rem - 1;
               if (m_rem == 0) begin
                  void'(q_lvl.pop_front());
                  void'(q_len.pop_front());
                  if (q_len.size() == 0) m_done = 1'b1;
                  else m_rem = q_len[0];
               end
            end
         end else if (start) begin
            int n;
            n = (int'(frame_len) > MAXB) ? MAXB : int'(frame_len);
            for (int k = 0; k < n; k++) begin
               q_lvl.push_back(0);
               q_len.push_back(PAUSE);
               q_lvl.push_back(1);
               q_len.push_back(frame_data[k] ? ONE - PAUSE : ZERO - PAUSE);
            end
            q_lvl.push_back(0);
            q_len.push_back(PAUSE);
            m_rem = q_len[0];
            frames_started++;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // Compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int ec;
         int eb;
         ec = (q_len.size() == 0) ? 1 : q_lvl[0];
         eb = (q_len.size() != 0) ? 1 : 0;
         check(cur_req, "carrier_en", int'(carrier_en), ec);
         check(cur_req, "busy", int'(busy), eb);
         check(cur_req, "done", int'(done), int'(m_done));
         check(cur_req, "timer_restart", int'(timer_restart), int'(m_done));
         if (done) dut_done_cnt++;
      end
   end

   // Tick generator
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      div_cnt = (div_cnt + 1) % 3;
      case (tick_mode)
         0: tick_en = 1'b1;
         1: tick_en = (div_cnt == 0);
         default: tick_en = lfsr[0];
      endcase
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R7 watchdog: actual=hung expected=frame completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic launch(input logic [MAXB-1:0] d, input int len);
      @(negedge clk);
      frame_data = d;
      frame_len  = LW'(len);
      start      = 1'b1;
      @(negedge clk);
      start      = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (q_len.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [MAXB-1:0] d, input int len);
      launch(d, len);
      wait_idle();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "reset carrier_en", int'(carrier_en), 1);
      check("R1", "reset busy", int'(busy), 0);
      check("R1", "reset done", int'(done), 0);

      // R11: ticks while idle do nothing
      cur_req = "R11";
      repeat (20) @(negedge clk);

      // R2 / R3: mixed pattern, sparse ticks
      cur_req = "R3";
      tick_mode = 1;
      launch(16'h000D, 4);
      check("R2", "busy after start", int'(busy), 1);
      check("R2", "carrier after start", int'(carrier_en), 0);
      wait_idle();

      cur_req = "R4";
      tick_mode = 0;
      send(16'h0001, 1);
      cur_req = "R6";
      send(16'h0002, 2);

      cur_req = "R5";
      send(16'hFFFF, 16);
      send(16'h0000, 16);

      // R8: start during a frame is ignored
      cur_req = "R8";
      launch(16'h0005, 3);
      repeat (10) @(negedge clk);
      frame_data = 16'hFFFF;
      frame_len  = LW'(16);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      check("R8", "frames accepted", frames_started, 6);

      cur_req = "R9";
      send(16'hFFFF, 0);

      cur_req = "R10";
      send(16'hA5C3, 20);
      send(16'h5A3C, 31);

      cur_req = "R11";
      tick_mode = 2;
      send(16'h1234, 13);
      send(16'hBEEF, 16);

      cur_req = "R7";
      tick_mode = 1;
      send(16'h0003, 2);
      repeat (5) @(negedge clk);
      check("R7", "done pulse count", dut_done_cnt, frames_started);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule